// File: doc/BRIEF.md
# FIFO Write-Port Steering and Configuration Register Front End

This block sits on the input clock of a synchronous FIFO and decides, for every clock edge, where the word on its 36-bit data input goes. A 3-bit port address chooses between seven 16-bit configuration registers and the FIFO memory path. The registers are base, offset, almost-full offset, almost-empty offset, parity, control and mailbox. A 2-bit width code trims the word to 9, 18 or 36 bits before it reaches the memory.

Register writes ignore the two data enables. They take the low 16 bits of the input whenever the address is one of the seven register codes. The all-ones address locks the register file. Only under that address does the block issue a memory write, and only when both enables are high. The memory array, the read side and the flag logic lie outside the block. It hands them a registered write strobe, the masked data word and the register contents. If a memory write is attempted with the reserved width code, the write is dropped and an error bit is set. That bit stays set until reset.

Top module: `fwf_wr_front`

## Requirements
- R1: While rst_n is low at a rising clock edge, the block loads its reset values. base_q, ofs_q, parity_q and mbox_q become 0. afull_q and aempty_q become 8. ctrl_q becomes 1. mem_we and width_err become 0.
- R2: With port_addr not equal to 3'b111, the rising edge writes din[15:0] into one register. The codes are 3'b000 for base_q, 3'b001 for ofs_q, 3'b010 for afull_q, 3'b011 for parity_q, 3'b100 for aempty_q, 3'b101 for ctrl_q and 3'b110 for mbox_q. The new value is visible after that edge, and the other registers keep their values.
- R3: With port_addr equal to 3'b111, no register changes on that edge.
- R4: The values of wen_a and wen_b have no effect on register writes.
- R5: mem_we is high in the cycle after an edge only if, at that edge, port_addr was 3'b111, wen_a and wen_b were both 1, and wsel was not 2'b10.
- R6: When a memory write is made with wsel 2'b00, mem_wdata carries din[8:0] and zeros in bits 35:9.
- R7: When a memory write is made with wsel 2'b01, mem_wdata carries din[17:0] and zeros in bits 35:18.
- R8: When a memory write is made with wsel 2'b11, mem_wdata carries all of din[35:0].
- R9: An edge with port_addr 3'b111, both enables high and wsel 2'b10 makes no memory write and sets width_err. width_err then stays at 1 until the next reset.
- R10: A register-mode address with both enables high makes no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input-side clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 36 | Incoming data word |
| port_addr | input | 3 | Destination select: register code or memory (3'b111) |
| wsel | input | 2 | Data width code for the memory path |
| wen_a | input | 1 | First memory write enable |
| wen_b | input | 1 | Second memory write enable |
| mem_we | output | 1 | Registered memory write strobe |
| mem_wdata | output | 36 | Masked data for the memory write |
| base_q | output | 16 | Base register |
| ofs_q | output | 16 | Offset register |
| afull_q | output | 16 | Almost-full offset register |
| parity_q | output | 16 | Parity register |
| aempty_q | output | 16 | Almost-empty offset register |
| ctrl_q | output | 16 | Control register |
| mbox_q | output | 16 | Mailbox register |
| width_err | output | 1 | Sticky reserved-width error |

## Verification
Every result in this block appears exactly one clock edge after its stimulus: register contents, the memory strobe with its masked data, and the error bit all come from a single flop stage. The bench drives inputs on the falling edge and pushes the expected state for the next rising edge into a queue. A monitor pops one entry 2 ns after each rising edge, so it compares values settled by the edge that consumed those inputs. The mask data is compared only in cycles where a write is expected.

// File: rtl/fwf_pkg.sv
// Package: shared constants and reset values for the FIFO write front end.
// Assumes seven configuration registers addressed by codes 0..6, code 7 = memory.
package fwf_pkg;

    localparam int ADDR_W   = 3;
    localparam int NREG     = 7;
    localparam logic [ADDR_W-1:0] MEM_CODE = 3'b111;

    typedef enum logic [1:0] {
        WID_NARROW = 2'b00,
        WID_MID    = 2'b01,
        WID_BAD    = 2'b10,
        WID_FULL   = 2'b11
    } width_code_t;

    // Reset value of register slot idx (almost-full/empty = 8, control = 1).
    function automatic int reg_default(input int idx);
        case (idx)
            2, 4:    return 8;
            5:       return 1;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/fwf_width_mask.sv
// Module: clears data bits above the width chosen by the width code.
// Assumes NARROW_W < MID_W <= DATA_W; the reserved code yields all zeros.
module fwf_width_mask #(
    parameter int DATA_W   = 36,
    parameter int NARROW_W = 9,
    parameter int MID_W    = 18
) (
    input  logic [DATA_W-1:0] din,
    input  logic [1:0]        wsel,
    output logic [DATA_W-1:0] dout
);
    import fwf_pkg::*;

    logic [DATA_W-1:0] keep;

    // Per-bit keep flag from the width code.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        always_comb begin
            keep[i] = (wsel == WID_FULL)
                    || ((wsel == WID_MID)    && (i < MID_W))
                    || ((wsel == WID_NARROW) && (i < NARROW_W));
        end
    end

    // Apply the mask.
    always_comb dout = din & keep;

endmodule

// File: rtl/fwf_addr_decode.sv
// Module: turns the port address, enables and width code into register write
// strobes, a memory-write request and a reserved-width flag. Purely combinational.
module fwf_addr_decode #(
    parameter int ADDR_W = 3,
    parameter int NREG   = 7
) (
    input  logic [ADDR_W-1:0] port_addr,
    input  logic              wen_a,
    input  logic              wen_b,
    input  logic [1:0]        wsel,
    output logic [NREG-1:0]   reg_we,
    output logic              mem_go,
    output logic              width_bad
);
    import fwf_pkg::*;

    logic mem_mode;
    logic both_en;

    // Memory mode and enable qualification.
    always_comb begin
        mem_mode = (port_addr == MEM_CODE);
        both_en  = wen_a && wen_b;
    end

    // One strobe per register slot; enables intentionally unused here.
    for (genvar k = 0; k < NREG; k++) begin : g_we
        always_comb reg_we[k] = (port_addr == ADDR_W'(k));
    end

    // Memory request and reserved-width detection.
    always_comb begin
        mem_go    = mem_mode && both_en && (wsel != WID_BAD);
        width_bad = mem_mode && both_en && (wsel == WID_BAD);
    end

endmodule

// File: rtl/fwf_regfile.sv
// Module: bank of configuration registers, each with its own reset value.
// Assumes at most one strobe in reg_we is set per cycle.
module fwf_regfile #(
    parameter int NREG  = 7,
    parameter int REG_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREG-1:0]   reg_we,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  regs [NREG]
);
    import fwf_pkg::*;

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        localparam logic [REG_W-1:0] RST_VAL = REG_W'(reg_default(k));
        // Slot k: reset to its default, else load on its strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[k] <= RST_VAL;
            else if (reg_we[k])
                regs[k] <= wdata;
        end
    end

endmodule

// File: rtl/fwf_wr_front.sv
// Module: write-side front end of a synchronous FIFO. Steers each input word
// to a configuration register or, at address 3'b111, to the memory path with
// width masking. Assumes a single input clock and synchronous active-low reset.
module fwf_wr_front #(
    parameter int DATA_W   = 36,
    parameter int REG_W    = 16,
    parameter int NARROW_W = 9,
    parameter int MID_W    = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic [2:0]        port_addr,
    input  logic [1:0]        wsel,
    input  logic              wen_a,
    input  logic              wen_b,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [REG_W-1:0]  base_q,
    output logic [REG_W-1:0]  ofs_q,
    output logic [REG_W-1:0]  afull_q,
    output logic [REG_W-1:0]  parity_q,
    output logic [REG_W-1:0]  aempty_q,
    output logic [REG_W-1:0]  ctrl_q,
    output logic [REG_W-1:0]  mbox_q,
    output logic              width_err
);
    import fwf_pkg::*;

    logic [NREG-1:0]   reg_we;
    logic              mem_go;
    logic              width_bad;
    logic [DATA_W-1:0] masked;
    logic [REG_W-1:0]  regs [NREG];

    fwf_addr_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
        .port_addr (port_addr),
        .wen_a     (wen_a),
        .wen_b     (wen_b),
        .wsel      (wsel),
        .reg_we    (reg_we),
        .mem_go    (mem_go),
        .width_bad (width_bad)
    );

    fwf_width_mask #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .MID_W(MID_W)) u_mask (
        .din  (din),
        .wsel (wsel),
        .dout (masked)
    );

    fwf_regfile #(.NREG(NREG), .REG_W(REG_W)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .reg_we (reg_we),
        .wdata  (din[REG_W-1:0]),
        .regs   (regs)
    );

    // Memory strobe and data stage; data held between writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_wdata <= '0;
        end else begin
            mem_we <= mem_go;
            if (mem_go)
                mem_wdata <= masked;
        end
    end

    // Sticky reserved-width error, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            width_err <= 1'b0;
        else if (width_bad)
            width_err <= 1'b1;
    end

    // Register slots out to named ports.
    always_comb begin
        base_q   = regs[0];
        ofs_q    = regs[1];
        afull_q  = regs[2];
        parity_q = regs[3];
        aempty_q = regs[4];
        ctrl_q   = regs[5];
        mbox_q   = regs[6];
    end

endmodule

// File: rtl/fwf_wr_front_chk.sv
// Checker: port-level properties of the write front end, bound to the top.
module fwf_wr_front_chk #(
    parameter int DATA_W   = 36,
    parameter int REG_W    = 16,
    parameter int NARROW_W = 9,
    parameter int MID_W    = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] din,
    input logic [2:0]        port_addr,
    input logic [1:0]        wsel,
    input logic              wen_a,
    input logic              wen_b,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [REG_W-1:0]  base_q,
    input logic [REG_W-1:0]  ofs_q,
    input logic [REG_W-1:0]  afull_q,
    input logic [REG_W-1:0]  parity_q,
    input logic [REG_W-1:0]  aempty_q,
    input logic [REG_W-1:0]  ctrl_q,
    input logic [REG_W-1:0]  mbox_q,
    input logic              width_err
);

    assert_reset_vals_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (afull_q == REG_W'(8) && aempty_q == REG_W'(8)
                           && ctrl_q == REG_W'(1) && !mem_we && !width_err));

    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (port_addr == 3'b101) |=> (ctrl_q == $past(din[REG_W-1:0])));

    assert_mbox_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (port_addr == 3'b110 && !wen_a) |=> (mbox_q == $past(din[REG_W-1:0])));

    assert_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (port_addr == 3'b111) |=> ($stable(base_q) && $stable(ofs_q) && $stable(afull_q)
            && $stable(parity_q) && $stable(aempty_q) && $stable(ctrl_q) && $stable(mbox_q)));

    assert_mem_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(port_addr == 3'b111 && wen_a && wen_b && wsel != 2'b10));

    assert_narrow_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(wsel) == 2'b00) |-> (mem_wdata[DATA_W-1:NARROW_W] == '0));

    assert_mid_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(wsel) == 2'b01) |-> (mem_wdata[DATA_W-1:MID_W] == '0));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        width_err |=> width_err);

    assert_reg_no_mem_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (port_addr != 3'b111) |=> !mem_we);

endmodule

bind fwf_wr_front fwf_wr_front_chk #(
    .DATA_W(DATA_W), .REG_W(REG_W), .NARROW_W(NARROW_W), .MID_W(MID_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .din(din), .port_addr(port_addr), .wsel(wsel),
    .wen_a(wen_a), .wen_b(wen_b), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .base_q(base_q), .ofs_q(ofs_q), .afull_q(afull_q), .parity_q(parity_q),
    .aempty_q(aempty_q), .ctrl_q(ctrl_q), .mbox_q(mbox_q), .width_err(width_err)
);

// File: tb/sim_fwf_wr_front.sv
// Scoreboard bench: the driver pushes expected post-edge state, the monitor compares.
module sim_fwf_wr_front;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [35:0] din = '0;
    logic [2:0]  port_addr = 3'b111;
    logic [1:0]  wsel = 2'b11;
    logic        wen_a = 1'b0;
    logic        wen_b = 1'b0;
    logic        mem_we;
    logic [35:0] mem_wdata;
    logic [15:0] base_q, ofs_q, afull_q, parity_q, aempty_q, ctrl_q, mbox_q;
    logic        width_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic        we;
        logic [35:0] data;
        logic [15:0] r [7];
        logic        err;
        string       tag;
    } exp_t;

    exp_t        sb [$];
    logic [15:0] mdl [7];
    logic        mdl_err;

    always #4 clk = ~clk;

    fwf_wr_front u0 (
        .clk(clk), .rst_n(rst_n), .din(din), .port_addr(port_addr), .wsel(wsel),
        .wen_a(wen_a), .wen_b(wen_b), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .base_q(base_q), .ofs_q(ofs_q), .afull_q(afull_q), .parity_q(parity_q),
        .aempty_q(aempty_q), .ctrl_q(ctrl_q), .mbox_q(mbox_q), .width_err(width_err)
    );

    task automatic check(input string tag, input string what,
                         input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [35:0] mask_of(input logic [1:0] w, input logic [35:0] d);
        case (w)
            2'b00:   return {27'd0, d[8:0]};
            2'b01:   return {18'd0, d[17:0]};
            default: return d;
        endcase
    endfunction

    // Reset cycle: expect the R1 values after the edge.
    task automatic do_reset();
        exp_t e;
        @(negedge clk);
        rst_n = 1'b0;
        mdl = '{16'd0, 16'd0, 16'd8, 16'd0, 16'd8, 16'd1, 16'd0};
        mdl_err = 1'b0;
        e.we = 1'b0; e.data = '0; e.r = mdl; e.err = 1'b0; e.tag = "R1";
        sb.push_back(e);
    endtask

    // One stimulus cycle; the model follows the requirements.
    task automatic drive(input logic [2:0] a, input logic [1:0] w, input logic ea,
                         input logic eb, input logic [35:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = 1'b1;
        port_addr = a; wsel = w; wen_a = ea; wen_b = eb; din = d;
        e.we   = (a == 3'b111) && ea && eb && (w != 2'b10);
        e.data = mask_of(w, d);
        if ((a == 3'b111) && ea && eb && (w == 2'b10)) mdl_err = 1'b1;
        if (a != 3'b111) mdl[a] = d[15:0];
        e.r = mdl; e.err = mdl_err; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: 2 ns after each rising edge, compare against the oldest entry.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                logic [15:0] act [7];
                e = sb.pop_front();
                act = '{base_q, ofs_q, afull_q, parity_q, aempty_q, ctrl_q, mbox_q};
                check(e.tag, "mem_we", {35'd0, mem_we}, {35'd0, e.we});
                if (e.we) check(e.tag, "mem_wdata", mem_wdata, e.data);
                for (int k = 0; k < 7; k++)
                    check(e.tag, $sformatf("reg%0d", k), {20'd0, act[k]}, {20'd0, e.r[k]});
                check(e.tag, "width_err", {35'd0, width_err}, {35'd0, e.err});
            end
        end
    end

    initial begin
        do_reset();
        do_reset();
        // R2: every register code, enables low
        for (int k = 0; k < 7; k++)
            drive(3'(k), 2'b11, 1'b0, 1'b0, 36'hA_0000_0000 | 36'(16'h1111 * (k + 1)), "R2");
        // R4 / R10: register writes with enables high, no memory write
        drive(3'b101, 2'b11, 1'b1, 1'b1, 36'hF_FFFF_BEEF, "R4");
        drive(3'b010, 2'b00, 1'b1, 1'b0, 36'h0_0000_0042, "R10");
        // R5 / R8 / R3: full-width memory write, registers locked
        drive(3'b111, 2'b11, 1'b1, 1'b1, 36'h9_8765_4321, "R8");
        drive(3'b111, 2'b11, 1'b1, 1'b0, 36'h1_2345_6789, "R5");
        drive(3'b111, 2'b11, 1'b0, 1'b1, 36'h1_2345_6789, "R5");
        drive(3'b111, 2'b11, 1'b0, 1'b0, 36'h0_DEAD_CAFE, "R3");
        // R6 / R7: narrow and mid widths
        drive(3'b111, 2'b00, 1'b1, 1'b1, 36'hF_FFFF_FFFF, "R6");
        drive(3'b111, 2'b01, 1'b1, 1'b1, 36'hF_FFFF_FFFF, "R7");
        drive(3'b111, 2'b01, 1'b1, 1'b1, 36'h5_5555_5555, "R7");
        // R9: reserved width, then stays set across later good writes
        drive(3'b111, 2'b10, 1'b1, 1'b1, 36'h7_7777_7777, "R9");
        drive(3'b111, 2'b11, 1'b1, 1'b1, 36'h3_3333_3333, "R9");
        drive(3'b000, 2'b11, 1'b0, 1'b0, 36'h0_0000_ABCD, "R9");
        // R1: reset clears the error and restores defaults
        do_reset();
        drive(3'b111, 2'b11, 1'b0, 1'b0, 36'h0, "R1");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        #(8 * 5000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule